// File: doc/BRIEF.md
# Interruptible multi-register transfer sequencer

This block walks a 16-entry register list on behalf of a load-multiple, store-multiple, push or pop operation. It presents one register index at a time on a request/acknowledge transfer port, always picking the lowest-numbered register still pending and skipping clear list bits. Memory and the register file sit outside the block. They see only the index, the transfer direction and the handshake.

An interrupt request may arrive while a list is in flight. The sequencer never abandons a transfer that is already being offered. It waits for that transfer's acknowledge, then parks. On parking it raises a one-cycle interrupt acknowledge and records the number of the next pending register in a 4-bit continuation field. That field is also published inside a 32-bit status word at bits 15:12, and every other bit of the word reads as zero. A resume strobe later restarts the walk from the recorded register, so the transfers already done are not repeated. If the interrupt lands on the final transfer, the operation simply completes and the field returns to zero.

Top module: `mrt_seq`

## Requirements
- R1: After a start with a non-empty list, `xfer_req` is high in the following cycle and `xfer_reg` names the lowest set bit of the list. Each `xfer_ack` retires that register, and the next lowest set bit is offered in the following cycle. Registers are therefore offered in strictly ascending order, and clear bits are skipped.
- R2: While `xfer_req` is high and `xfer_ack` is low, `xfer_req`, `xfer_reg` and `xfer_wr` hold their values.
- R3: `op` encodes 0 = load, 1 = store, 2 = push, 3 = pop. `xfer_wr` is 1 for store and push and 0 for load and pop.
- R4: Suppose `irq_req` is high in the cycle a transfer is acknowledged, and list registers remain. In the next cycle the block parks: `irq_ack` is high for exactly one cycle, `xfer_req` is low, `busy` is high, and `cont_idx` holds the next pending register number.
- R5: `cont_word[15:12]` equals `cont_idx`, and all other bits of `cont_word` are zero. This includes bits 26:25 and 11:10.
- R6: A `resume` pulse while parked makes `xfer_req` high in the next cycle, with `xfer_reg` equal to the saved `cont_idx`. The remaining registers then complete in order, and none transferred before the park is repeated.
- R7: If `irq_req` is high when the last register is acknowledged, the operation completes instead of parking. In the next cycle `done` is high, `busy` is low and `cont_idx` is 0. The request is acknowledged from idle one cycle later.
- R8: A `resume` pulse while idle, where `cont_idx` is zero, replays the most recently started list from its lowest set bit.
- R9: A start with an empty list sets `done` high for one cycle in the next cycle and never raises `xfer_req`.
- R10: `start` is ignored while `busy` is high, whether the block is running or parked. The offered register and the saved field are unchanged.
- R11: During and straight after reset, `xfer_req`, `busy`, `done` and `irq_ack` are low and `cont_word` is zero.
- R12: An `irq_req` while idle, with no start in the same cycle, gives a single-cycle `irq_ack` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled while idle |
| reg_list | input | 16 | Register list, bit n selects register n |
| op | input | 2 | Operation: 0 load, 1 store, 2 push, 3 pop |
| resume | input | 1 | Resume strobe |
| xfer_ack | input | 1 | Transfer acknowledge |
| irq_req | input | 1 | Interrupt request level, held until acknowledged |
| xfer_req | output | 1 | Transfer request |
| xfer_reg | output | 4 | Register index of the current transfer |
| xfer_wr | output | 1 | 1 = register to memory, 0 = memory to register |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| busy | output | 1 | Operation running or parked |
| done | output | 1 | One-cycle completion pulse |
| cont_idx | output | 4 | Continuation field: next register to transfer |
| cont_word | output | 32 | Status word carrying the continuation field at bits 15:12 |

## Verification
The properties assume that `irq_req` is a level held until `irq_ack` and dropped in the cycle that follows. They also assume that `xfer_ack` arrives only while `xfer_req` is high, and that `resume` is pulsed only while parked or idle. The bench drives every input half a cycle away from the active edge. It raises the interrupt only while a transfer is being offered, acknowledges only offered transfers, and drops `irq_req` as soon as it sees the acknowledge. Random lists, operations, handshake stalls and interrupt points stay inside these rules. Directed cases cover the top register, the final transfer and the empty list.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_PUSH  = 2'd2,
      OP_POP   = 2'd3
   } mrt_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_PARK = 2'd2
   } mrt_state_e;

   // register-to-memory direction for the given operation
   function automatic logic op_writes(input logic [1:0] o);
      return (o == OP_STORE) || (o == OP_PUSH);
   endfunction

endpackage

// File: rtl/mrt_lowbit.sv
// Lowest-set-bit index encoder; two equivalent structures selectable.
module mrt_lowbit #(
   parameter int W          = 16,
   parameter int IDX_W      = 4,
   parameter bit ONEHOT_ENC = 1'b1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx
);

   if (W > (1 << IDX_W)) begin : g_bad_width
      $error("mrt_lowbit: IDX_W too narrow for W");
   end

   if (ONEHOT_ENC) begin : g_onehot
      logic [W-1:0] iso;
      assign iso = vec & (~vec + W'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < W; i++) begin
            if (iso[i]) idx = idx | IDX_W'(i);
         end
      end
   end else begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mrt_tailmask.sv
// Keeps list bits at or above a given index.
module mrt_tailmask #(
   parameter int W     = 16,
   parameter int IDX_W = 4
) (
   input  logic [W-1:0]     list,
   input  logic [IDX_W-1:0] from,
   output logic [W-1:0]     tail
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign tail[i] = list[i] & (from <= IDX_W'(i));
   end

endmodule

// File: rtl/mrt_status.sv
// Places the continuation field into the status word; other bits zero.
module mrt_status #(
   parameter int IDX_W    = 4,
   parameter int WORD_W   = 32,
   parameter int CONT_LSB = 12
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word
);

   if (CONT_LSB + IDX_W > WORD_W) begin : g_bad_place
      $error("mrt_status: continuation field does not fit the word");
   end

   always_comb begin
      word = '0;
      word[CONT_LSB +: IDX_W] = idx;
   end

endmodule

// File: rtl/mrt_ctrl.sv
// Sequencing state machine: run, park on interrupt, resume, complete.
module mrt_ctrl
   import mrt_pkg::*;
#(
   parameter int NREG  = 16,
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NREG-1:0]   reg_list,
   input  logic [1:0]        op,
   input  logic              resume,
   input  logic              xfer_ack,
   input  logic              irq_req,
   input  logic [NREG-1:0]   rem_nxt,
   input  logic [IDX_W-1:0]  nxt_idx,
   input  logic [NREG-1:0]   resume_mask,
   output mrt_state_e        state,
   output logic [NREG-1:0]   rem,
   output logic [NREG-1:0]   list_q,
   output logic [1:0]        op_q,
   output logic [IDX_W-1:0]  cont_q,
   output logic              done,
   output logic              irq_ack
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rem     <= '0;
         list_q  <= '0;
         op_q    <= OP_LOAD;
         cont_q  <= '0;
         done    <= 1'b0;
         irq_ack <= 1'b0;
      end else begin
         done    <= 1'b0;
         irq_ack <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  list_q <= reg_list;
                  op_q   <= op;
                  cont_q <= '0;
                  rem    <= reg_list;
                  if (|reg_list) state <= ST_RUN;
                  else           done  <= 1'b1;
               end else if (resume) begin
                  rem <= resume_mask;
                  if (|resume_mask) state <= ST_RUN;
                  else              done  <= 1'b1;
               end else if (irq_req && !irq_ack) begin
                  irq_ack <= 1'b1;
               end
            end
            ST_RUN: begin
               if (xfer_ack) begin
                  rem <= rem_nxt;
                  if (!(|rem_nxt)) begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     cont_q <= '0;
                  end else if (irq_req) begin
                     state   <= ST_PARK;
                     irq_ack <= 1'b1;
                     cont_q  <= nxt_idx;
                  end
               end
            end
            ST_PARK: begin
               if (resume) begin
                  rem   <= resume_mask;
                  state <= ST_RUN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
   import mrt_pkg::*;
#(
   parameter int  NREG       = 16,
   parameter int  WORD_W     = 32,
   parameter int  CONT_LSB   = 12,
   parameter bit  ONEHOT_ENC = 1'b1,
   localparam int IDX_W      = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NREG-1:0]   reg_list,
   input  logic [1:0]        op,
   input  logic              resume,
   input  logic              xfer_ack,
   input  logic              irq_req,
   output logic              xfer_req,
   output logic [IDX_W-1:0]  xfer_reg,
   output logic              xfer_wr,
   output logic              irq_ack,
   output logic              busy,
   output logic              done,
   output logic [IDX_W-1:0]  cont_idx,
   output logic [WORD_W-1:0] cont_word
);

   if (NREG < 2 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("mrt_seq: NREG must be a power of two of at least 2");
   end

   mrt_state_e        state;
   logic [NREG-1:0]   rem, rem_nxt, list_q, resume_mask;
   logic [1:0]        op_q;
   logic [IDX_W-1:0]  cur_idx, nxt_idx, cont_q;

   mrt_lowbit #(.W(NREG), .IDX_W(IDX_W), .ONEHOT_ENC(ONEHOT_ENC)) u_enc_cur (
      .vec (rem),
      .idx (cur_idx)
   );

   assign rem_nxt = rem & ~(NREG'(1) << cur_idx);

   mrt_lowbit #(.W(NREG), .IDX_W(IDX_W), .ONEHOT_ENC(ONEHOT_ENC)) u_enc_nxt (
      .vec (rem_nxt),
      .idx (nxt_idx)
   );

   mrt_tailmask #(.W(NREG), .IDX_W(IDX_W)) u_tail (
      .list (list_q),
      .from (cont_q),
      .tail (resume_mask)
   );

   mrt_ctrl #(.NREG(NREG), .IDX_W(IDX_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .reg_list    (reg_list),
      .op          (op),
      .resume      (resume),
      .xfer_ack    (xfer_ack),
      .irq_req     (irq_req),
      .rem_nxt     (rem_nxt),
      .nxt_idx     (nxt_idx),
      .resume_mask (resume_mask),
      .state       (state),
      .rem         (rem),
      .list_q      (list_q),
      .op_q        (op_q),
      .cont_q      (cont_q),
      .done        (done),
      .irq_ack     (irq_ack)
   );

   mrt_status #(.IDX_W(IDX_W), .WORD_W(WORD_W), .CONT_LSB(CONT_LSB)) u_status (
      .idx  (cont_q),
      .word (cont_word)
   );

   assign xfer_req = (state == ST_RUN);
   assign xfer_reg = cur_idx;
   assign xfer_wr  = op_writes(op_q);
   assign busy     = (state != ST_IDLE);
   assign cont_idx = cont_q;

endmodule

// File: rtl/mrt_seq_chk.sv
module mrt_seq_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             resume,
   input logic             xfer_ack,
   input logic             irq_req,
   input logic             xfer_req,
   input logic [IDX_W-1:0] xfer_reg,
   input logic             xfer_wr,
   input logic             irq_ack,
   input logic             busy,
   input logic             done,
   input logic [IDX_W-1:0] cont_idx
);

   // R1
   ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && xfer_ack |=> !xfer_req || (xfer_reg > $past(xfer_reg)));

   // R2
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_reg) && $stable(xfer_wr));

   // R4
   park_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && busy |-> !xfer_req && (cont_idx != '0));

   // R4
   single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   // R10
   park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !xfer_req && !resume |=> busy && !xfer_req && $stable(cont_idx));

   // R7
   done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && (cont_idx == '0));

   // R8
   idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cont_idx == '0);

   // R6
   resume_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !xfer_req && resume |=> xfer_req && (xfer_reg == $past(cont_idx)));

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && !irq_ack |=> xfer_req || done);

endmodule

bind mrt_seq mrt_seq_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .resume   (resume),
   .xfer_ack (xfer_ack),
   .irq_req  (irq_req),
   .xfer_req (xfer_req),
   .xfer_reg (xfer_reg),
   .xfer_wr  (xfer_wr),
   .irq_ack  (irq_ack),
   .busy     (busy),
   .done     (done),
   .cont_idx (cont_idx)
);

// File: tb/mrt_seq_test.sv
`timescale 1ns/1ps
module mrt_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] reg_list = '0;
   logic [1:0]  op = '0;
   logic        resume = 1'b0;
   logic        xfer_ack = 1'b0;
   logic        irq_req = 1'b0;
   logic        xfer_req, xfer_wr, irq_ack, busy, done;
   logic [3:0]  xfer_reg, cont_idx;
   logic [31:0] cont_word;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   mrt_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list), .op(op),
      .resume(resume), .xfer_ack(xfer_ack), .irq_req(irq_req),
      .xfer_req(xfer_req), .xfer_reg(xfer_reg), .xfer_wr(xfer_wr),
      .irq_ack(irq_ack), .busy(busy), .done(done), .cont_idx(cont_idx),
      .cont_word(cont_word)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   function automatic bit exp_wr(input logic [1:0] o);
      return (o == 2'd1) || (o == 2'd2);
   endfunction

   function automatic longint exp_word(input int idx);
      return longint'(idx) << 12;
   endfunction

   // Walks the expected transfers from the current negedge.
   task automatic run_xfers(input logic [15:0] lst, input logic [1:0] o,
                            input int irq_at, input bit poke, input string tag0);
      int n = 0;
      int seq[16];
      string tag = tag0;
      for (int i = 0; i < 16; i++) if (lst[i]) begin seq[n] = i; n++; end
      if (n == 0) begin
         chk(done === 1'b1 && xfer_req === 1'b0, "R9", {done, xfer_req}, 2'b10);
         @(negedge clk);
         chk(done === 1'b0 && xfer_req === 1'b0, "R9", {done, xfer_req}, 2'b00);
         return;
      end
      for (int k = 0; k < n; k++) begin
         chk(xfer_req === 1'b1 && xfer_reg == 4'(seq[k]), tag, xfer_reg, seq[k]);
         chk(xfer_wr === exp_wr(o), "R3", xfer_wr, exp_wr(o));
         tag = "R1";
         if (k == irq_at) irq_req = 1'b1;
         if (poke && k == 0) begin
            start = 1'b1; reg_list = ~lst;
            @(negedge clk);
            start = 1'b0;
            chk(xfer_req === 1'b1 && xfer_reg == 4'(seq[k]), "R10", xfer_reg, seq[k]);
         end
         repeat ($urandom % 3) begin
            @(negedge clk);
            chk(xfer_req === 1'b1 && xfer_reg == 4'(seq[k]), "R2", xfer_reg, seq[k]);
         end
         xfer_ack = 1'b1;
         @(negedge clk);
         xfer_ack = 1'b0;
         if (k == n - 1) begin
            chk(done === 1'b1 && busy === 1'b0 && irq_ack === 1'b0,
                (k == irq_at) ? "R7" : "R1", {done, busy, irq_ack}, 3'b100);
            chk(cont_idx == 4'd0 && cont_word == 32'd0, "R7", cont_word, 0);
            if (k == irq_at) begin
               @(negedge clk);
               chk(irq_ack === 1'b1 && done === 1'b0, "R7", irq_ack, 1);
               irq_req = 1'b0;
               @(negedge clk);
            end
         end else if (k == irq_at) begin
            chk(irq_ack === 1'b1 && busy === 1'b1 && xfer_req === 1'b0, "R4",
                {irq_ack, busy, xfer_req}, 3'b110);
            chk(cont_idx == 4'(seq[k+1]), "R4", cont_idx, seq[k+1]);
            chk(longint'(cont_word) == exp_word(seq[k+1]), "R5", cont_word, exp_word(seq[k+1]));
            irq_req = 1'b0;
            start = 1'b1; reg_list = 16'hFFFF;
            @(negedge clk);
            start = 1'b0;
            chk(irq_ack === 1'b0 && xfer_req === 1'b0 && busy === 1'b1 &&
                cont_idx == 4'(seq[k+1]), "R10", cont_idx, seq[k+1]);
            repeat ($urandom % 4) @(negedge clk);
            resume = 1'b1;
            @(negedge clk);
            resume = 1'b0;
            tag = "R6";
         end
      end
   endtask

   task automatic do_op(input logic [15:0] lst, input logic [1:0] o,
                        input int irq_at, input bit poke);
      start = 1'b1; reg_list = lst; op = o;
      @(negedge clk);
      start = 1'b0;
      run_xfers(lst, o, irq_at, poke, "R1");
   endtask

   task automatic do_replay(input logic [15:0] lst, input logic [1:0] o);
      resume = 1'b1;
      @(negedge clk);
      resume = 1'b0;
      run_xfers(lst, o, -1, 1'b0, "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(xfer_req === 1'b0 && busy === 1'b0 && done === 1'b0 && irq_ack === 1'b0,
          "R11", {xfer_req, busy, done, irq_ack}, 0);
      chk(cont_word === 32'd0, "R11", cont_word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(xfer_req === 1'b0 && busy === 1'b0 && cont_word === 32'd0, "R11", busy, 0);

      // R12 interrupt while idle
      irq_req = 1'b1;
      @(negedge clk);
      chk(irq_ack === 1'b1 && busy === 1'b0, "R12", irq_ack, 1);
      irq_req = 1'b0;
      @(negedge clk);
      chk(irq_ack === 1'b0, "R12", irq_ack, 0);

      // directed corners
      do_op(16'h8001, 2'd1, 0, 1'b1);   // park with field 15
      do_op(16'h8000, 2'd0, 0, 1'b0);   // interrupt on final transfer
      do_op(16'h0000, 2'd3, -1, 1'b0);  // empty list
      do_op(16'hFFFF, 2'd2, 14, 1'b0);  // park before the top register
      do_replay(16'hFFFF, 2'd2);
      do_op(16'h0A50, 2'd3, 1, 1'b1);
      do_replay(16'h0A50, 2'd3);

      // constrained random
      for (int t = 0; t < 300; t++) begin
         logic [15:0] l;
         logic [1:0]  o;
         int          n;
         int          ia;
         l = 16'($urandom);
         if ($urandom % 8 == 0) l = l & 16'($urandom) & 16'($urandom);
         o = 2'($urandom);
         n = $countones(l);
         ia = (n > 0 && ($urandom % 2 == 0)) ? int'($urandom % n) : -1;
         do_op(l, o, ia, ($urandom % 10) == 0);
         if ($urandom % 6 == 0) do_replay(l, o);
      end

      summary();
      $finish;
   end

endmodule